// File: doc/BRIEF.md
# ISA Slave Address Decode and Byte-Lane Steering

This block is the host-side front end of a peripheral that sits on a 16-bit or 8-bit ISA-style I/O bus. It compares the upper five I/O address bits with five base-address straps to decide whether the peripheral is selected. A strap tied low matches a 0 and a strap left open (pulled up) matches a 1, so base 0x2C0 is chosen with straps 10110. The low five address bits pick one of 32 byte registers, held here in a simple array that stands in for the real register file.

Which data byte lane carries the register depends on a bus-width strap, the active-low byte-high enable and the address LSB. One FIFO offset (0x18) is special: a full-width access there moves the lower FIFO byte on the low lane and its partner byte at 0x19 on the high lane in the same cycle. The block drives the active-low 16-bit-access indication, flags lane combinations that are not allowed, produces one-cycle read and write strobes with the register offset, and holds a ready line low for a configurable number of clocks on registers marked as slow.

Top module: `isa_lane_steer`

## Requirements
- R1: The block responds (lane enables, strobes, register writes, lane error, ready) only when `io_addr[9:5]` equals `base_strap` and `aen_n` is 0. With straps 10110 the base is 0x2C0, and address 0x2E0 does not select it.
- R2: A lower-lane access (bus8_strap=1 with bhe_n=1 at any offset, or bus8_strap=0 with bhe_n=1 at an even offset) reads the register on `rdata[7:0]` with `lo_oe`=1 and `hi_oe`=0, writes it from `wdata[7:0]`, and keeps `cs16_n` at 1.
- R3: With bus8_strap=0, bhe_n=0 and an odd offset, the register moves on `rdata[15:8]`/`wdata[15:8]` with `hi_oe`=1 and `lo_oe`=0; the lower write lane is ignored and `cs16_n` is 0.
- R4: With bus8_strap=0, bhe_n=0 and offset 0x18, both lanes move together: low lane is register 0x18, high lane is register 0x19; both enables are 1 and `cs16_n` is 0.
- R5: The register is chosen by `io_addr[4:0]` alone: a byte written on one lane is read back through the other lane at the same offset.
- R6: A register is written when `iow_n` rises; while `iow_n` is still low, no write strobe appears and the register keeps its old value.
- R7: Bus8_strap=0 with bhe_n=0 at an even offset other than 0x18, bus8_strap=0 with bhe_n=1 at an odd offset, and bus8_strap=1 with bhe_n=0 are illegal: during a strobe `lane_err` is 1, and no lane is enabled, no strobe fires, no register changes and ready is not pulled.
- R8: An access to an offset whose bit in `SLOW_MASK` is set (by default 0x06 and 0x07) holds `rdy_low` at 1 for exactly `WAIT_CLKS` (default 4) clocks from the clock edge that sees the strobe fall; other offsets never assert it, and it drops once both strobes are high.
- R9: `rd_stb` is a one-clock pulse after the clock edge that sees `ior_n` fall, `wr_stb` a one-clock pulse after the edge that sees `iow_n` rise, each with the offset on `reg_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 10 | I/O address from the bus |
| aen_n | input | 1 | Address enable, active low |
| base_strap | input | 5 | Base-address straps, compared with io_addr[9:5] |
| bhe_n | input | 1 | Byte-high enable, active low |
| bus8_strap | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| wdata | input | 16 | Write data, both lanes |
| rdata | output | 16 | Read data, both lanes; 0 on a lane that is not enabled |
| lo_oe | output | 1 | Lower lane driven |
| hi_oe | output | 1 | Upper lane driven |
| cs16_n | output | 1 | Active-low 16-bit access indication |
| rdy_low | output | 1 | 1 = pull the ready line low; 0 = leave it undriven |
| lane_err | output | 1 | Illegal lane combination during a strobe |
| rd_stb | output | 1 | Register read strobe |
| wr_stb | output | 1 | Register write strobe |
| reg_off | output | 5 | Register offset for the strobes |

## Verification
The write latch and the wait-state timer can act in the same clock: a host may release `iow_n` on a slow register while the ready line is still held low. The bench provokes this by raising the write strobe two clocks into a four-clock wait on offset 0x07 and judges that the write strobe pulses, the new byte reads back and the ready pull drops at the very next sample. A second overlap, both lanes at the FIFO offset, is judged by writing two distinct bytes in one cycle and reading each back through a single-lane access.

// File: rtl/isa_lane_steer.sv
module isa_lane_steer #(
  parameter int ADDR_W = 10,
  parameter int OFF_W = 5,
  parameter logic [4:0] FIFO_OFF = 5'h18,
  parameter int WAIT_CLKS = 4,
  parameter logic [31:0] SLOW_MASK = 32'h0000_00C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              aen_n,
  input  logic [ADDR_W-OFF_W-1:0] base_strap,
  input  logic              bhe_n,
  input  logic              bus8_strap,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              lo_oe,
  output logic              hi_oe,
  output logic              cs16_n,
  output logic              rdy_low,
  output logic              lane_err,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [OFF_W-1:0]  reg_off
);
  localparam int NREG = 1 << OFF_W;
  localparam int CNT_W = $clog2(WAIT_CLKS + 1);

  logic [7:0] regs [NREG];
  logic [OFF_W-1:0] off, pair_hi;
  logic sel, bhe, pair, hi_only, lo_only, legal, uses_hi, uses_lo, ok, slow;
  logic ior_q, iow_q, rd_fall, wr_fall, wr_rise;
  logic [CNT_W-1:0] wait_cnt;

  assign off     = io_addr[OFF_W-1:0];
  assign pair_hi = {off[OFF_W-1:1], 1'b1};
  assign sel     = !aen_n && (io_addr[ADDR_W-1:OFF_W] == base_strap);
  assign bhe     = !bhe_n;
  assign pair    = !bus8_strap && bhe && (off == FIFO_OFF[OFF_W-1:0]);
  assign hi_only = !bus8_strap && bhe && off[0];
  assign lo_only = !bhe && (bus8_strap || !off[0]);
  assign legal   = pair || hi_only || lo_only;
  assign uses_hi = pair || hi_only;
  assign uses_lo = pair || lo_only;
  assign ok      = sel && legal;
  assign slow    = SLOW_MASK[off];

  assign cs16_n   = !(sel && uses_hi);
  assign lane_err = sel && !legal && (!ior_n || !iow_n);
  assign lo_oe    = ok && !ior_n && uses_lo;
  assign hi_oe    = ok && !ior_n && uses_hi;

  assign rdata[7:0]  = lo_oe ? regs[off] : 8'h00;
  assign rdata[15:8] = hi_oe ? (pair ? regs[pair_hi] : regs[off]) : 8'h00;

  assign rd_fall = ok && ior_q && !ior_n;
  assign wr_fall = ok && iow_q && !iow_n;
  assign wr_rise = ok && !iow_q && iow_n;
  assign rdy_low = (wait_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ior_q   <= 1'b1;
      iow_q   <= 1'b1;
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
      reg_off <= '0;
    end else begin
      ior_q  <= ior_n;
      iow_q  <= iow_n;
      rd_stb <= rd_fall;
      wr_stb <= wr_rise;
      if (rd_fall || wr_rise) reg_off <= off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if ((rd_fall || wr_fall) && slow) begin
      wait_cnt <= CNT_W'(WAIT_CLKS);
    end else if (ior_n && iow_n) begin
      wait_cnt <= '0;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else if (wr_rise) begin
      if (uses_lo) regs[off] <= wdata[7:0];
      if (pair) regs[pair_hi] <= wdata[15:8];
      else if (hi_only) regs[off] <= wdata[15:8];
    end
  end
endmodule

// File: rtl/isa_lane_steer_chk.sv
module isa_lane_steer_chk #(
  parameter int ADDR_W = 10,
  parameter int OFF_W = 5,
  parameter logic [4:0] FIFO_OFF = 5'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              aen_n,
  input logic [ADDR_W-OFF_W-1:0] base_strap,
  input logic              ior_n,
  input logic              iow_n,
  input logic              lo_oe,
  input logic              hi_oe,
  input logic              cs16_n,
  input logic              rdy_low,
  input logic              lane_err,
  input logic              rd_stb,
  input logic              wr_stb
);
  logic hit;
  assign hit = !aen_n && (io_addr[ADDR_W-1:OFF_W] == base_strap);

  AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!lo_oe && !hi_oe && !lane_err && cs16_n)); // R1
  AST_HI_LANE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ior_n && !cs16_n && !lane_err) |-> hi_oe); // R3
  AST_BOTH_LANES_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_oe && hi_oe) |-> (io_addr[OFF_W-1:0] == FIFO_OFF[OFF_W-1:0])); // R4
  AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(iow_n) && $past(!iow_n, 2))); // R6
  AST_ILLEGAL_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    lane_err |-> (!lo_oe && !hi_oe)); // R7
  AST_READY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_low |-> $past(!ior_n || !iow_n)); // R8
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R9
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R9
endmodule

bind isa_lane_steer isa_lane_steer_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FIFO_OFF(FIFO_OFF)
) i_chk (.*);

// File: tb/test_isa_lane_steer.sv
module test_isa_lane_steer;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] BASE = 10'h2C0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] io_addr = BASE;
  logic aen_n = 1'b1, bhe_n = 1'b1, bus8_strap = 1'b0, ior_n = 1'b1, iow_n = 1'b1;
  logic [4:0] base_strap = 5'b10110;
  logic [15:0] wdata = '0, rdata;
  logic lo_oe, hi_oe, cs16_n, rdy_low, lane_err, rd_stb, wr_stb;
  logic [4:0] reg_off;
  int checks = 0, errors = 0;

  isa_lane_steer i_isa_lane_steer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic io_wr(input logic [9:0] a, input logic bhe, input logic [15:0] d,
                       output logic stb, output logic err, output logic early);
    @(negedge clk);
    io_addr = a; aen_n = 1'b0; bhe_n = !bhe; wdata = d; iow_n = 1'b0;
    @(negedge clk);
    err = lane_err; early = wr_stb;
    repeat (2) @(negedge clk);
    early = early | wr_stb;
    iow_n = 1'b1;
    @(negedge clk);
    stb = wr_stb;
    aen_n = 1'b1; bhe_n = 1'b1;
  endtask

  task automatic io_rd(input logic [9:0] a, input logic bhe, output logic [15:0] d,
                       output logic lo, output logic hi, output logic cs, output logic stb);
    @(negedge clk);
    io_addr = a; aen_n = 1'b0; bhe_n = !bhe; ior_n = 1'b0;
    #1 d = rdata; lo = lo_oe; hi = hi_oe; cs = cs16_n;
    @(negedge clk);
    stb = rd_stb;
    ior_n = 1'b1; aen_n = 1'b1; bhe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8", "ready at reset", rdy_low, 1'b0);
    chk("R9", "strobes at reset", {rd_stb, wr_stb}, 2'b00);
    chk("R1", "lanes at reset", {lo_oe, hi_oe, cs16_n}, 3'b001);
  endtask

  task automatic t_lower;
    logic s, e, x, lo, hi, cs; logic [15:0] d;
    bus8_strap = 1'b0;
    io_wr(BASE | 10'h02, 1'b0, 16'hEE5A, s, e, x);
    chk("R2", "even lo write strobe", s, 1'b1);
    io_rd(BASE | 10'h02, 1'b0, d, lo, hi, cs, s);
    chk("R2", "even lo data", d, 16'h005A);
    chk("R2", "even lo enables/cs16", {lo, hi, cs}, 3'b101);
    chk("R9", "read strobe", s, 1'b1);
    chk("R9", "strobe offset", reg_off, 5'h02);
    bus8_strap = 1'b1;
    io_wr(BASE | 10'h05, 1'b0, 16'h11A5, s, e, x);
    io_rd(BASE | 10'h05, 1'b0, d, lo, hi, cs, s);
    chk("R2", "8-bit odd lo data", d, 16'h00A5);
    chk("R2", "8-bit odd enables/cs16", {lo, hi, cs}, 3'b101);
  endtask

  task automatic t_upper_and_same_reg;
    logic s, e, x, lo, hi, cs; logic [15:0] d;
    bus8_strap = 1'b0;
    io_rd(BASE | 10'h05, 1'b1, d, lo, hi, cs, s);
    chk("R5", "byte from lo lane read on hi lane", d, 16'hA500);
    chk("R3", "odd hi enables/cs16", {lo, hi, cs}, 3'b010);
    io_wr(BASE | 10'h03, 1'b1, 16'h3C77, s, e, x);
    chk("R3", "odd hi write strobe", s, 1'b1);
    bus8_strap = 1'b1;
    io_rd(BASE | 10'h03, 1'b0, d, lo, hi, cs, s);
    chk("R3", "hi lane byte stored, lo ignored", d, 16'h003C);
    io_rd(BASE | 10'h02, 1'b0, d, lo, hi, cs, s);
    chk("R3", "neighbour untouched", d, 16'h005A);
    bus8_strap = 1'b0;
  endtask

  task automatic t_pair;
    logic s, e, x, lo, hi, cs; logic [15:0] d;
    bus8_strap = 1'b0;
    io_wr(BASE | 10'h18, 1'b1, 16'hB7C4, s, e, x);
    io_rd(BASE | 10'h18, 1'b1, d, lo, hi, cs, s);
    chk("R4", "paired data", d, 16'hB7C4);
    chk("R4", "paired enables/cs16", {lo, hi, cs}, 3'b110);
    io_rd(BASE | 10'h18, 1'b0, d, lo, hi, cs, s);
    chk("R4", "0x18 alone", d, 16'h00C4);
    io_rd(BASE | 10'h19, 1'b1, d, lo, hi, cs, s);
    chk("R4", "0x19 alone", d, 16'hB700);
  endtask

  task automatic t_edge;
    logic s, e, x, lo, hi, cs; logic [15:0] d;
    io_wr(BASE | 10'h0A, 1'b0, 16'h0066, s, e, x);
    chk("R6", "no write strobe while low", x, 1'b0);
    chk("R9", "write strobe after rise", s, 1'b1);
    chk("R9", "write offset", reg_off, 5'h0A);
    @(negedge clk);
    chk("R9", "write strobe one cycle", wr_stb, 1'b0);
    io_rd(BASE | 10'h0A, 1'b0, d, lo, hi, cs, s);
    chk("R6", "written value", d, 16'h0066);
  endtask

  task automatic t_select;
    logic s, e, x, lo, hi, cs; logic [15:0] d;
    io_wr(10'h2E0 | 10'h0A, 1'b0, 16'h0099, s, e, x);
    chk("R1", "other base no strobe", {s, e}, 2'b00);
    @(negedge clk);
    io_addr = BASE | 10'h0A; aen_n = 1'b1; iow_n = 1'b0; wdata = 16'h0099;
    repeat (2) @(negedge clk);
    iow_n = 1'b1;
    @(negedge clk);
    chk("R1", "aen high no strobe", wr_stb, 1'b0);
    io_rd(BASE | 10'h0A, 1'b0, d, lo, hi, cs, s);
    chk("R1", "register unchanged", d, 16'h0066);
    base_strap = 5'b10111;
    io_rd(10'h2E0 | 10'h0A, 1'b0, d, lo, hi, cs, s);
    chk("R1", "new strap base selects", d, 16'h0066);
    base_strap = 5'b10110;
  endtask

  task automatic t_illegal;
    logic s, e, x, lo, hi, cs; logic [15:0] d;
    bus8_strap = 1'b0;
    io_wr(BASE | 10'h04, 1'b1, 16'h1234, s, e, x);
    chk("R7", "even bhe 16-bit flag/strobe", {e, s}, 2'b10);
    io_wr(BASE | 10'h09, 1'b0, 16'h0055, s, e, x);
    chk("R7", "odd no-bhe 16-bit flag/strobe", {e, s}, 2'b10);
    bus8_strap = 1'b1;
    io_wr(BASE | 10'h06, 1'b1, 16'h7788, s, e, x);
    chk("R7", "8-bit bhe flag/strobe", {e, s}, 2'b10);
    io_rd(BASE | 10'h06, 1'b1, d, lo, hi, cs, s);
    chk("R7", "illegal read no lanes", {lo, hi, s}, 3'b000);
    io_rd(BASE | 10'h04, 1'b0, d, lo, hi, cs, s);
    chk("R7", "0x04 unchanged", d, 16'h0000);
    io_rd(BASE | 10'h09, 1'b0, d, lo, hi, cs, s);
    chk("R7", "0x09 unchanged", d, 16'h0000);
    io_rd(BASE | 10'h06, 1'b0, d, lo, hi, cs, s);
    chk("R7", "0x06 unchanged", d, 16'h0000);
    bus8_strap = 1'b0;
  endtask

  task automatic t_wait;
    int n;
    @(negedge clk);
    io_addr = BASE | 10'h06; aen_n = 1'b0; bhe_n = 1'b1; ior_n = 1'b0;
    n = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); n += int'(rdy_low); end
    chk("R8", "slow register wait clocks", n, 4);
    ior_n = 1'b1; aen_n = 1'b1;
    @(negedge clk);
    io_addr = BASE | 10'h02; aen_n = 1'b0; ior_n = 1'b0;
    n = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); n += int'(rdy_low); end
    chk("R8", "fast register no wait", n, 0);
    ior_n = 1'b1; aen_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_overlap;
    logic s, lo, hi, cs; logic [15:0] d;
    bus8_strap = 1'b0;
    @(negedge clk);
    io_addr = BASE | 10'h07; aen_n = 1'b1; bhe_n = 1'b1;
    bus8_strap = 1'b1; aen_n = 1'b0; wdata = 16'h00D2; iow_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "ready pulled mid wait", rdy_low, 1'b1);
    iow_n = 1'b1;
    @(negedge clk);
    chk("R8", "ready released with strobe", rdy_low, 1'b0);
    chk("R6", "write lands during wait", wr_stb, 1'b1);
    aen_n = 1'b1;
    io_rd(BASE | 10'h07, 1'b0, d, lo, hi, cs, s);
    chk("R6", "slow register value", d, 16'h00D2);
    bus8_strap = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lower();
    t_upper_and_same_reg();
    t_pair();
    t_edge();
    t_select();
    t_illegal();
    t_wait();
    t_overlap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule